// File: doc/BRIEF.md
# Hit Acceptance and Epoch Message Builder

This block collects hit words from several front-end readout chips and turns them into a single ordered stream of messages. Each chip presents one hit word at a time. A hit word comes with a data-valid strobe, an even-parity bit and the 12-bit fine-time offset at which the hit was stamped. A per-chip enable mask decides whether a chip's strobe is honoured at all. Every honoured strobe raises a one-cycle activity pulse for that chip. An optional parity check turns a corrupted hit into a parity-error message in place of the hit.

The block is given the low 44 bits of the free-running local timestamp counter. The upper 32 of those bits form the epoch number and the lower 12 form the offset within the epoch. When the epoch number moves away from the last one announced, the block emits an epoch marker message. It first finishes every hit already held. While the marker is outstanding it takes in no new hits, so each hit message lands behind the marker of the epoch it belongs to. Each hit also carries a late flag. The flag says that the hit's offset is ahead of the counter's offset at capture, which means the hit belongs to the epoch before the current one.

Each chip has a one-entry holding slot. A three-state machine moves messages to the output: IDLE, HIT (a hit or parity-error message is presented) and EPOCH (a marker is presented). The transitions are named as follows. IDLE→HIT is taken when any slot is full, and the lowest-numbered full slot wins. IDLE→EPOCH is taken when no slot is full and the epoch is stale. HIT→IDLE and EPOCH→IDLE are taken on msg_ready. HIT and EPOCH stay put while msg_ready is low.

Top module: `hit_msg_builder`

## Requirements
- R1: A chip whose chip_mask bit is 0 has its hit_valid ignored. Nothing is captured, no message is produced and its hit_seen bit stays 0.
- R2: hit_seen[n] is high for exactly the one cycle after the clock edge at which chip n's hit was captured.
- R3: With parity_en at 1, a captured hit whose data bits XOR its parity bit gives 1 (even parity violated) becomes a message with msg_kind 2 (parity error). That message carries the chip number and the hit offset, with msg_data 0 and msg_late 0 unless the late rule applies.
- R4: With parity_en at 0, every captured hit becomes a hit message (msg_kind 0), whatever its parity bit.
- R5: A hit message carries the chip number in msg_chip, the hit offset in msg_ofs and the hit word zero-extended in msg_data. Every captured hit yields exactly one message.
- R6: msg_late is 1 on a hit or parity-error message exactly when the hit's offset is greater than ts_now[11:0] in the capture cycle.
- R7: When ts_now[43:12] differs from the last announced epoch, an epoch marker is emitted with msg_kind 1 and msg_data equal to ts_now[43:12]. Until that marker is loaded, hit_ready is 0 for every chip. The announced epoch is 0 after reset.
- R8: Hits captured in the same cycle are emitted in order from chip 0 upward. Hits already held are emitted before a pending epoch marker.
- R9: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and all message fields stay unchanged.
- R10: After reset, msg_valid is 0, hit_seen is 0 and hit_ready is all ones.
- R11: hit_ready[n] is 0 while chip n's hit is held. A hit_valid presented while hit_ready is 0 is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_mask | input | NCHIP | Per-chip enable, bit n for chip n |
| parity_en | input | 1 | 1 enables the even-parity check |
| ts_now | input | 44 | Low 44 bits of the local timestamp counter |
| hit_valid | input | NCHIP | Data-valid strobe per chip |
| hit_par | input | NCHIP | Parity bit per chip |
| hit_data | input | NCHIP x HIT_W | Hit word per chip |
| hit_ofs | input | NCHIP x 12 | Fine-time offset stamped on each hit |
| hit_ready | output | NCHIP | Chip slot can accept a hit |
| hit_seen | output | NCHIP | One-cycle activity pulse per captured hit |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_kind | output | 2 | 0 hit, 1 epoch marker, 2 parity error |
| msg_chip | output | log2(NCHIP) | Source chip of a hit or parity error |
| msg_late | output | 1 | Hit belongs to the previous epoch |
| msg_ofs | output | 12 | Hit offset within its epoch |
| msg_data | output | 32 | Hit word or epoch number |

## Verification
The bench builds the block with its defaults: four chips, 16-bit hit words, 12 offset bits and 32 epoch bits. With these values all four chips can contend in one cycle, so the chip-0-first ordering and the slot holding can be observed. Random traffic covers random masks, parity settings, parity bits, offsets and a randomly stalled msg_ready. Epoch jumps are placed between bursts and, in a directed case, while hits are still held. That case shows the ready gate and the marker falling in behind the held hits. Directed cases also hit the late flag exactly at and just past equal offsets, and a strobe on a chip whose slot is full.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

    typedef enum logic [1:0] {
        MSG_HIT    = 2'd0,
        MSG_EPOCH  = 2'd1,
        MSG_PARERR = 2'd2
    } msg_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_EPOCH = 2'd2
    } fsm_t;

endpackage

// File: rtl/hmb_slot.sv
module hmb_slot #(
    parameter int HIT_W = 16,
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             pop_i,
    input  logic [HIT_W-1:0] data_i,
    input  logic             par_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [OFS_W-1:0] now_ofs_i,
    input  logic             par_en_i,
    output logic             full_o,
    output logic [HIT_W-1:0] data_o,
    output logic [OFS_W-1:0] ofs_o,
    output logic             late_o,
    output logic             bad_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            data_o <= '0;
            ofs_o  <= '0;
            late_o <= 1'b0;
            bad_o  <= 1'b0;
        end else if (cap_i) begin
            full_o <= 1'b1;
            data_o <= data_i;
            ofs_o  <= ofs_i;
            late_o <= (ofs_i > now_ofs_i);
            bad_o  <= par_en_i & (^{data_i, par_i});
        end else if (pop_i) begin
            full_o <= 1'b0;
        end
    end

    AST_CAP_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |-> !full_o); // R11

    AST_POP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> full_o); // R5

    AST_NO_BAD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && !par_en_i) |=> !bad_o); // R4

endmodule

// File: rtl/hmb_pick.sv
module hmb_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/hit_msg_builder.sv
module hit_msg_builder #(
    parameter int NCHIP   = 4,
    parameter int HIT_W   = 16,
    parameter int OFS_W   = 12,
    parameter int EPOCH_W = 32,
    localparam int CHIP_W = (NCHIP > 1) ? $clog2(NCHIP) : 1,
    localparam int TS_W   = OFS_W + EPOCH_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCHIP-1:0]            chip_mask,
    input  logic                        parity_en,
    input  logic [TS_W-1:0]             ts_now,
    input  logic [NCHIP-1:0]            hit_valid,
    input  logic [NCHIP-1:0]            hit_par,
    input  logic [NCHIP-1:0][HIT_W-1:0] hit_data,
    input  logic [NCHIP-1:0][OFS_W-1:0] hit_ofs,
    output logic [NCHIP-1:0]            hit_ready,
    output logic [NCHIP-1:0]            hit_seen,
    output logic                        msg_valid,
    input  logic                        msg_ready,
    output logic [1:0]                  msg_kind,
    output logic [CHIP_W-1:0]           msg_chip,
    output logic                        msg_late,
    output logic [OFS_W-1:0]            msg_ofs,
    output logic [EPOCH_W-1:0]          msg_data
);
    import hmb_pkg::*;

    fsm_t               state_q, state_d;
    logic [EPOCH_W-1:0] epoch_q;
    logic [EPOCH_W-1:0] epoch_now;
    logic [OFS_W-1:0]   ofs_now;
    logic               open;

    logic [NCHIP-1:0]   cap, pop, full, late, bad;
    logic [HIT_W-1:0]   s_data [NCHIP];
    logic [OFS_W-1:0]   s_ofs  [NCHIP];
    logic               pick_any;
    logic [CHIP_W-1:0]  pick_idx;

    assign epoch_now = ts_now[TS_W-1:OFS_W];
    assign ofs_now   = ts_now[OFS_W-1:0];
    assign open      = (epoch_now == epoch_q);
    assign hit_ready = ~full & {NCHIP{open}};
    assign cap       = hit_valid & chip_mask & hit_ready;

    genvar g;
    generate
        for (g = 0; g < NCHIP; g++) begin : g_slot
            assign pop[g] = (state_q == ST_IDLE) && pick_any && (pick_idx == CHIP_W'(g));

            hmb_slot #(.HIT_W(HIT_W), .OFS_W(OFS_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .cap_i     (cap[g]),
                .pop_i     (pop[g]),
                .data_i    (hit_data[g]),
                .par_i     (hit_par[g]),
                .ofs_i     (hit_ofs[g]),
                .now_ofs_i (ofs_now),
                .par_en_i  (parity_en),
                .full_o    (full[g]),
                .data_o    (s_data[g]),
                .ofs_o     (s_ofs[g]),
                .late_o    (late[g]),
                .bad_o     (bad[g])
            );

            AST_SEEN_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
                hit_seen[g] |-> $past(chip_mask[g] && hit_valid[g])); // R1
        end
    endgenerate

    hmb_pick #(.N(NCHIP), .IW(CHIP_W)) u_pick (
        .req_i (full),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any)   state_d = ST_HIT;
                else if (!open) state_d = ST_EPOCH;
            end
            ST_HIT, ST_EPOCH: begin
                if (msg_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign msg_valid = (state_q != ST_IDLE);

    // output and epoch registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epoch_q  <= '0;
            hit_seen <= '0;
            msg_kind <= '0;
            msg_chip <= '0;
            msg_late <= 1'b0;
            msg_ofs  <= '0;
            msg_data <= '0;
        end else begin
            hit_seen <= cap;
            if (state_q == ST_IDLE) begin
                if (pick_any) begin
                    msg_kind <= bad[pick_idx] ? MSG_PARERR : MSG_HIT;
                    msg_chip <= pick_idx;
                    msg_late <= late[pick_idx];
                    msg_ofs  <= s_ofs[pick_idx];
                    msg_data <= bad[pick_idx] ? '0 : EPOCH_W'(s_data[pick_idx]);
                end else if (!open) begin
                    msg_kind <= MSG_EPOCH;
                    msg_chip <= '0;
                    msg_late <= 1'b0;
                    msg_ofs  <= '0;
                    msg_data <= epoch_now;
                    epoch_q  <= epoch_now;
                end
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_kind)
                                       && $stable(msg_chip) && $stable(msg_ofs))); // R9

    AST_HIT_BEFORE_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pick_any) |=> (msg_valid && msg_kind != MSG_EPOCH)); // R8

    AST_EPOCH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_EPOCH) |-> (msg_data == epoch_q)); // R7

    AST_NO_CAP_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        !open |-> (hit_ready == '0)); // R7

endmodule

// File: tb/hit_msg_builder_tb.sv
module hit_msg_builder_tb;

    localparam int NCHIP = 4;
    localparam int HIT_W = 16;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [NCHIP-1:0]            chip_mask = '1;
    logic                        parity_en = 1'b0;
    logic [43:0]                 ts_now = '0;
    logic [NCHIP-1:0]            hit_valid = '0;
    logic [NCHIP-1:0]            hit_par = '0;
    logic [NCHIP-1:0][HIT_W-1:0] hit_data = '0;
    logic [NCHIP-1:0][11:0]      hit_ofs = '0;
    logic [NCHIP-1:0]            hit_ready;
    logic [NCHIP-1:0]            hit_seen;
    logic                        msg_valid;
    logic                        msg_ready = 1'b0;
    logic [1:0]                  msg_kind;
    logic [1:0]                  msg_chip;
    logic                        msg_late;
    logic [11:0]                 msg_ofs;
    logic [31:0]                 msg_data;

    hit_msg_builder u_dut (
        .clk(clk), .rst_n(rst_n), .chip_mask(chip_mask), .parity_en(parity_en),
        .ts_now(ts_now), .hit_valid(hit_valid), .hit_par(hit_par), .hit_data(hit_data),
        .hit_ofs(hit_ofs), .hit_ready(hit_ready), .hit_seen(hit_seen),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_chip(msg_chip), .msg_late(msg_late), .msg_ofs(msg_ofs), .msg_data(msg_data)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [48:0] q_msg [32];
    int qh = 0;
    int qt = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit exp_bad(input logic [15:0] d, input logic p, input logic en);
        return en && (^{d, p});
    endfunction

    function automatic logic [48:0] exp_hit(input int c, input logic [15:0] d, input logic p,
                                            input logic en, input logic [11:0] hofs,
                                            input logic [11:0] nofs);
        bit b = exp_bad(d, p, en);
        return {b ? 2'd2 : 2'd0, 2'(c), hofs > nofs, hofs, b ? 32'd0 : {16'd0, d}};
    endfunction

    task automatic push(input logic [48:0] m);
        q_msg[qt] = m;
        qt++;
    endtask

    task automatic drain(input int maxc, input bit rnd);
        for (int k = 0; k < maxc; k++) begin
            @(negedge clk);
            msg_ready = rnd ? 1'($urandom % 2) : 1'b1;
            if (msg_valid && msg_ready) begin
                if (qh == qt) begin
                    check(1'b0, "R1 unexpected message", 64'({msg_kind, msg_chip, msg_late, msg_ofs, msg_data}), 64'd0);
                end else begin
                    logic [48:0] act = {msg_kind, msg_chip, msg_late, msg_ofs, msg_data};
                    string tag = (q_msg[qh][48:47] == 2'd1) ? "R7 epoch marker" :
                                 (q_msg[qh][48:47] == 2'd2) ? "R3 parity message" : "R5/R6 hit message";
                    check(act == q_msg[qh], tag, 64'(act), 64'(q_msg[qh]));
                    qh++;
                end
            end
        end
        @(negedge clk);
        msg_ready = 1'b0;
        check(qh == qt, "R5 all messages delivered", 64'(qt - qh), 64'd0);
        qh = 0;
        qt = 0;
    endtask

    task automatic one_hit(input int c, input logic [15:0] d, input logic p, input logic [11:0] hofs,
                           input logic [11:0] nofs, input logic [3:0] mask, input logic en,
                           input logic [31:0] ep);
        @(negedge clk);
        chip_mask = mask;
        parity_en = en;
        ts_now = {ep, nofs};
        hit_valid = '0;
        hit_valid[c] = 1'b1;
        hit_data[c] = d;
        hit_par[c] = p;
        hit_ofs[c] = hofs;
        if (mask[c]) push(exp_hit(c, d, p, en, hofs, nofs));
        @(negedge clk);
        hit_valid = '0;
        check(hit_seen == (mask[c] ? (4'b1 << c) : 4'b0), "R1/R2 activity pulse",
              64'(hit_seen), 64'(mask[c] ? (4'b1 << c) : 4'b0));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ep;
        void'($urandom(32'd1234));
        ep = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(msg_valid == 1'b0, "R10 msg_valid after reset", 64'(msg_valid), 64'd0);
        check(hit_ready == 4'hF, "R10 hit_ready after reset", 64'(hit_ready), 64'hF);
        check(hit_seen == 4'h0, "R10 hit_seen after reset", 64'(hit_seen), 64'd0);

        // R8 priority: chips 3,1,0 together
        ts_now = {ep, 12'd100};
        hit_valid = 4'b1011;
        hit_data[0] = 16'h1111; hit_data[1] = 16'h2222; hit_data[3] = 16'h4444;
        hit_ofs[0] = 12'd1; hit_ofs[1] = 12'd2; hit_ofs[3] = 12'd3;
        hit_par = '0;
        push({2'd0, 2'd0, 1'b0, 12'd1, 32'h1111});
        push({2'd0, 2'd1, 1'b0, 12'd2, 32'h2222});
        push({2'd0, 2'd3, 1'b0, 12'd3, 32'h4444});
        @(negedge clk);
        check(hit_ready == 4'b0100, "R11 ready low on held slots", 64'(hit_ready), 64'h4);
        check(hit_seen == 4'b1011, "R2 activity pulses", 64'(hit_seen), 64'hB);
        // R11 strobe on a full slot is not captured
        hit_valid = 4'b1000;
        hit_data[3] = 16'hDEAD;
        @(negedge clk);
        hit_valid = '0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(msg_valid && msg_chip == 2'd0 && msg_data == 32'h1111, "R9 held under backpressure",
                  64'({msg_valid, msg_chip, msg_data}), 64'({1'b1, 2'd0, 32'h1111}));
        end
        drain(20, 1'b0);

        // R8/R7: held hits go before the epoch marker; capture closed while stale
        @(negedge clk);
        ts_now = {ep, 12'd10};
        hit_valid = 4'b0110;
        hit_data[1] = 16'hAAAA; hit_data[2] = 16'hBBBB;
        hit_ofs[1] = 12'd5; hit_ofs[2] = 12'd6;
        push({2'd0, 2'd1, 1'b0, 12'd5, 32'hAAAA});
        push({2'd0, 2'd2, 1'b0, 12'd6, 32'hBBBB});
        @(negedge clk);
        hit_valid = 4'b0001;
        hit_data[0] = 16'h5555;
        ep = ep + 32'd3;
        ts_now = {ep, 12'd10};
        #0;
        check(hit_ready == 4'b0000, "R7 no capture while epoch stale", 64'(hit_ready), 64'd0);
        push({2'd1, 2'd0, 1'b0, 12'd0, ep});
        @(negedge clk);
        hit_valid = '0;
        drain(20, 1'b0);

        // R3 directed parity
        one_hit(2, 16'h0001, 1'b1, 12'd7, 12'd50, 4'hF, 1'b1, ep);
        one_hit(2, 16'h0001, 1'b0, 12'd7, 12'd50, 4'hF, 1'b1, ep);
        drain(20, 1'b0);
        // R4 parity disabled, bad parity still a hit
        one_hit(1, 16'h0003, 1'b1, 12'd7, 12'd50, 4'hF, 1'b0, ep);
        drain(20, 1'b0);
        // R6 late flag boundary
        one_hit(0, 16'h0F0F, 1'b0, 12'd200, 12'd200, 4'hF, 1'b0, ep);
        one_hit(0, 16'h0F0F, 1'b0, 12'd201, 12'd200, 4'hF, 1'b0, ep);
        drain(20, 1'b0);
        // R1 masked chip
        one_hit(3, 16'h7777, 1'b0, 12'd1, 12'd2, 4'b0111, 1'b0, ep);
        drain(10, 1'b0);

        // random traffic
        for (int t = 0; t < 300; t++) begin
            int c = int'($urandom % 4);
            logic [3:0] m = 4'($urandom);
            if (($urandom % 4) != 0) m[c] = 1'b1;
            if ((t % 25) == 24) begin
                @(negedge clk);
                ep = ep + 32'($urandom % 5) + 32'd1;
                ts_now = {ep, 12'($urandom)};
                push({2'd1, 2'd0, 1'b0, 12'd0, ep});
                drain(30, 1'b1);
            end
            one_hit(c, 16'($urandom), 1'($urandom), 12'($urandom), 12'($urandom), m,
                    1'($urandom), ep);
            drain(30, 1'b1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule